// File: doc/BRIEF.md
# Pipelined Multi-Bank Shared Packet Buffer

This block is the central store of a small packet switch with N input links and N output links. All ports share one storage pool; there are no per-input queues. A packet is a fixed group of B words. Its words are striped across B memory banks, one word in each bank, and every bank uses the same slot address for that packet. One decision per cycle at bank 0 (either a write start or a read start) sets off a wave: bank k performs the same operation, on the same slot, k cycles later. This replaces one wide memory, or an interleaved one, with B narrow banks whose addresses are staggered.

A free-slot map hands out a slot to each write. At write start, the slot number is queued for the packet's destination output. An output may therefore begin reading the packet on the very next cycle, before the write wave has reached the last bank (cut-through). The slot goes back to the free map when the read wave leaves the last bank. When no slot is free, a requesting input is held off with a stall indication. No packet is ever dropped.

An input raises its request with the destination and word 0 on its data lane. In the cycle it sees its start grant, word 0 is taken, and words 1..B-1 must follow on the next B-1 cycles. Each output receives the words of a packet in B consecutive cycles, with a flag on word 0.

Top module: `sbuf_shared_buffer`

## Requirements
- R1: A packet written from any input to any output is delivered word for word on that output, and packets for one output come out in the order their write starts were granted.
- R2: An output presents a packet's words in B consecutive cycles, word k in the k-th of them, and out_first is high exactly with word 0.
- R3: At most one packet start (write or read) is made per cycle; at most one bit of in_start is high in any cycle.
- R4: A read start is made only in a cycle in which no input could start a write (no idle requester, or no free slot); while writes keep coming, reads wait.
- R5: Inputs that request together are granted round-robin; N inputs requesting in the same cycle with free slots available are all granted within N consecutive cycles, in different cycles.
- R6: An input granted in cycle t supplies word k in cycle t+k, and it is not granted again before cycle t+B; back-to-back packets from one otherwise idle input are granted exactly B cycles apart.
- R7: Cut-through: on an idle buffer, word 0 of a packet appears on its output two cycles after its write start, before its last word has been written.
- R8: in_stall of an input is high only while that input requests, is not sending a packet, and no slot is free; a stalled input gets no grant, and its packet is accepted once a slot returns.
- R9: A slot is returned after its read wave passes the last bank, so no slot is lost: after all traffic has drained, every packet has been delivered, and the whole slot pool can again be filled without a stall.
- R10: After reset, no output is valid, no input is stalled and every slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_req | input | N_PORTS | Per input: a packet is waiting to start |
| in_dest | input | N_PORTS*PW | Per input: destination output number |
| in_data | input | N_PORTS*WORD_W | Per input: current word lane (word 0 while requesting) |
| in_start | output | N_PORTS | Per input: word 0 is taken this cycle; words 1..B-1 follow |
| in_stall | output | N_PORTS | Per input: request refused, no free slot |
| out_valid | output | N_PORTS | Per output: a packet word is present |
| out_first | output | N_PORTS | Per output: the present word is word 0 |
| out_data | output | N_PORTS*WORD_W | Per output: packet word |

## Verification
The bench builds the block with four ports, four banks, 16-bit words and only four slots. With a pool that small, a single burst from all four inputs empties the free map, so the stall path, slot return and write-over-read priority are all reached within a few dozen cycles. The four-input burst also makes round-robin order and the one-start-per-cycle rule visible in the grant cycles. An isolated packet on the idle buffer exposes the exact cut-through latency.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  // Kind of operation travelling down the bank wave
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } sbuf_op_e;
endpackage

// File: rtl/sbuf_rr_arb.sv
module sbuf_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_idx,
  output logic          found
);
  logic [IW-1:0] ptr_q, ptr_d;

  // Search from the pointer upward, wrapping once
  always_comb begin
    int idx;
    grant     = '0;
    grant_idx = '0;
    found     = 1'b0;
    for (int off = 0; off < N; off++) begin
      idx = int'(ptr_q) + off;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found      = 1'b1;
        grant[idx] = 1'b1;
        grant_idx  = IW'(idx);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (found) begin
      if (grant_idx == IW'(N - 1)) ptr_d = '0;
      else                         ptr_d = grant_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/sbuf_bank.sv
module sbuf_bank #(
  parameter int W     = 16,
  parameter int SLOTS = 16,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [SW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [SLOTS];

  // One port: a write or a registered read per cycle
  always_ff @(posedge clk) begin
    if (en && we)  mem[addr] <= wdata;
    if (en && !we) rdata     <= mem[addr];
  end
endmodule

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    cnt_d = cnt_q + (AW+1)'(push) - (AW+1)'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/sbuf_free_map.sv
module sbuf_free_map #(
  parameter int SLOTS = 16,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  output logic [SW-1:0] take_slot,
  output logic          any_free,
  input  logic          give,
  input  logic [SW-1:0] give_slot
);
  logic [SLOTS-1:0] free_q, free_d;

  // Lowest free slot is handed out first
  always_comb begin
    take_slot = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (free_q[s]) take_slot = SW'(s);
    end
  end

  assign any_free = |free_q;

  always_comb begin
    free_d = free_q;
    if (take) free_d[take_slot] = 1'b0;
    if (give) free_d[give_slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_d;
  end
endmodule

// File: rtl/sbuf_shared_buffer.sv
module sbuf_shared_buffer #(
  parameter int N_PORTS = 8,
  parameter int BANKS   = 8,
  parameter int WORD_W  = 16,
  parameter int SLOTS   = 128,
  localparam int PW     = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        in_req,
  input  logic [N_PORTS*PW-1:0]     in_dest,
  input  logic [N_PORTS*WORD_W-1:0] in_data,
  output logic [N_PORTS-1:0]        in_start,
  output logic [N_PORTS-1:0]        in_stall,
  output logic [N_PORTS-1:0]        out_valid,
  output logic [N_PORTS-1:0]        out_first,
  output logic [N_PORTS*WORD_W-1:0] out_data
);
  import sbuf_pkg::*;

  typedef struct packed {
    sbuf_op_e      kind;
    logic [SW-1:0] slot;
    logic [PW-1:0] port;
  } wave_op_t;

  // Reset: asynchronous assert, synchronous release
  logic rst_s1, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_n_i <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_n_i <= rst_s1;
    end
  end

  // Wave stages: stg_q[k] is the operation at bank k this cycle
  wave_op_t stg_q [1:BANKS-1];
  wave_op_t stg_d [1:BANKS-1];
  wave_op_t op0;
  wave_op_t bank_op [BANKS];

  logic [N_PORTS-1:0] in_busy, out_busy;
  always_comb begin
    in_busy  = '0;
    out_busy = '0;
    for (int k = 1; k < BANKS; k++) begin
      if (stg_q[k].kind == OP_WRITE) in_busy[stg_q[k].port]  = 1'b1;
      if (stg_q[k].kind == OP_READ)  out_busy[stg_q[k].port] = 1'b1;
    end
  end

  // Free-slot map
  logic          free_any;
  logic [SW-1:0] free_slot;
  logic          give;
  logic [SW-1:0] give_slot;
  logic          wr_go, rd_go;

  sbuf_free_map #(.SLOTS(SLOTS)) u_free (
    .clk(clk), .rst_n(rst_n_i),
    .take(wr_go), .take_slot(free_slot), .any_free(free_any),
    .give(give), .give_slot(give_slot)
  );

  // Write-start arbitration among inputs
  logic [N_PORTS-1:0] wr_req;
  logic [PW-1:0]      wr_idx;
  assign wr_req = in_req & ~in_busy & {N_PORTS{free_any}};

  sbuf_rr_arb #(.N(N_PORTS)) u_in_arb (
    .clk(clk), .rst_n(rst_n_i), .req(wr_req),
    .grant(in_start), .grant_idx(wr_idx), .found(wr_go)
  );

  assign in_stall = in_req & ~in_busy & {N_PORTS{~free_any}};

  logic [PW-1:0] wr_dest;
  assign wr_dest = in_dest[int'(wr_idx)*PW +: PW];

  // Per-output queues of slot numbers
  logic [N_PORTS-1:0] q_empty;
  logic [N_PORTS-1:0] q_pop;
  logic [SW-1:0]      q_dout [N_PORTS];

  for (genvar o = 0; o < N_PORTS; o++) begin : g_outq
    logic push_o;
    assign push_o = wr_go && (wr_dest == PW'(o));
    sbuf_fifo #(.W(SW), .DEPTH(SLOTS)) u_q (
      .clk(clk), .rst_n(rst_n_i),
      .push(push_o), .din(free_slot),
      .pop(q_pop[o]), .dout(q_dout[o]), .empty(q_empty[o])
    );
  end

  // Read-start arbitration among outputs; writes go first
  logic [N_PORTS-1:0] rd_req;
  logic [PW-1:0]      rd_idx;
  assign rd_req = ~q_empty & ~out_busy & {N_PORTS{~wr_go}};

  sbuf_rr_arb #(.N(N_PORTS)) u_out_arb (
    .clk(clk), .rst_n(rst_n_i), .req(rd_req),
    .grant(q_pop), .grant_idx(rd_idx), .found(rd_go)
  );

  // Bank-0 decision
  always_comb begin
    op0 = '{kind: OP_IDLE, slot: '0, port: '0};
    if (wr_go) begin
      op0.kind = OP_WRITE;
      op0.slot = free_slot;
      op0.port = wr_idx;
    end else if (rd_go) begin
      op0.kind = OP_READ;
      op0.slot = q_dout[rd_idx];
      op0.port = rd_idx;
    end
  end

  // Wave shift: next state then register
  always_comb begin
    stg_d[1] = op0;
    for (int k = 2; k < BANKS; k++) stg_d[k] = stg_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int k = 1; k < BANKS; k++) stg_q[k] <= '{kind: OP_IDLE, slot: '0, port: '0};
    end else begin
      for (int k = 1; k < BANKS; k++) stg_q[k] <= stg_d[k];
    end
  end

  // Slot returns when the read wave leaves the last bank
  assign give      = (stg_q[BANKS-1].kind == OP_READ);
  assign give_slot = stg_q[BANKS-1].slot;

  // Banks and their read tags
  logic [WORD_W-1:0] bank_rdata [BANKS];
  logic [BANKS-1:0]  rt_vld_q, rt_vld_d;
  logic [PW-1:0]     rt_port_q [BANKS];
  logic [PW-1:0]     rt_port_d [BANKS];

  for (genvar k = 0; k < BANKS; k++) begin : g_bank
    if (k == 0) begin : g_head
      assign bank_op[k] = op0;
    end else begin : g_tail
      assign bank_op[k] = stg_q[k];
    end
    logic en_k, we_k;
    assign en_k = (bank_op[k].kind != OP_IDLE);
    assign we_k = (bank_op[k].kind == OP_WRITE);
    sbuf_bank #(.W(WORD_W), .SLOTS(SLOTS)) u_bank (
      .clk(clk), .en(en_k), .we(we_k), .addr(bank_op[k].slot),
      .wdata(in_data[int'(bank_op[k].port)*WORD_W +: WORD_W]),
      .rdata(bank_rdata[k])
    );
    assign rt_vld_d[k]  = (bank_op[k].kind == OP_READ);
    assign rt_port_d[k] = bank_op[k].port;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rt_vld_q <= '0;
      for (int k = 0; k < BANKS; k++) rt_port_q[k] <= '0;
    end else begin
      rt_vld_q <= rt_vld_d;
      for (int k = 0; k < BANKS; k++) rt_port_q[k] <= rt_port_d[k];
    end
  end

  // Output steering
  always_comb begin
    out_valid = '0;
    out_first = '0;
    out_data  = '0;
    for (int k = 0; k < BANKS; k++) begin
      if (rt_vld_q[k]) begin
        out_valid[rt_port_q[k]] = 1'b1;
        out_data[int'(rt_port_q[k])*WORD_W +: WORD_W] = bank_rdata[k];
      end
    end
    if (rt_vld_q[0]) out_first[rt_port_q[0]] = 1'b1;
  end
endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] in_req,
  input logic [N-1:0] in_start,
  input logic [N-1:0] in_stall,
  input logic [N-1:0] in_busy,
  input logic         free_any,
  input logic         wr_go,
  input logic         rd_go
);
  // R3: a single start per cycle at the head bank
  p_one_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && rd_go) && $onehot0(in_start));

  // R4: reads only when no write could start
  p_write_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> !((|(in_req & ~in_busy)) && free_any));

  // R6: an input still sending its words is not granted
  p_busy_no_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_start & in_busy) == '0);

  // R8: a stalled input receives no grant
  p_stall_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stall & in_start) == '0);

  // R8: stall only when the slot pool is empty
  p_stall_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_stall) |-> !free_any);

  // R6: a granted input stays busy in the following cycle
  p_grant_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_start) |=> ((in_busy & $past(in_start)) == $past(in_start)));
endmodule

bind sbuf_shared_buffer sbuf_checker #(.N(N_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n_i),
  .in_req(in_req), .in_start(in_start), .in_stall(in_stall),
  .in_busy(in_busy), .free_any(free_any),
  .wr_go(wr_go), .rd_go(rd_go)
);

// File: tb/sbuf_shared_buffer_bench.sv
module sbuf_shared_buffer_bench;
  localparam int N  = 4;
  localparam int B  = 4;
  localparam int W  = 16;
  localparam int S  = 4;
  localparam int PW = 2;

  logic clk, rst_n;
  logic [N-1:0]    in_req, in_start, in_stall, out_valid, out_first;
  logic [N*PW-1:0] in_dest;
  logic [N*W-1:0]  in_data, out_data;

  logic            req_a  [N];
  logic [PW-1:0]   dest_a [N];
  logic [W-1:0]    data_a [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      in_req[i]              = req_a[i];
      in_dest[i*PW +: PW]    = dest_a[i];
      in_data[i*W +: W]      = data_a[i];
    end
  end

  sbuf_shared_buffer #(.N_PORTS(N), .BANKS(B), .WORD_W(W), .SLOTS(S)) u_sbuf_shared_buffer (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_dest(in_dest), .in_data(in_data),
    .in_start(in_start), .in_stall(in_stall),
    .out_valid(out_valid), .out_first(out_first), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [W-1:0] exp_q [N][$];
  int  last_grant [N];
  int  grant_log  [$];
  int  stall_seen = 0;
  bit  mon_on = 0;
  bit  probe_on = 0;
  bit  burst_watch = 0;
  int  first_out_cyc = -1;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mkword(input int i, input int seq, input int k);
    return {i[3:0], seq[7:0], k[3:0]};
  endfunction

  // Driver: request, wait for the grant, then stream the remaining words
  task automatic send(input int i, input int d, input int seq);
    bit got = 0;
    @(negedge clk);
    req_a[i] = 1'b1; dest_a[i] = PW'(d); data_a[i] = mkword(i, seq, 0);
    while (!got) begin
      #5;
      if (in_start[i]) begin
        got = 1;
        last_grant[i] = cyc;
        grant_log.push_back(cyc);
        for (int k = 0; k < B; k++) exp_q[d].push_back(mkword(i, seq, k));
      end else begin
        if (in_stall[i]) stall_seen++;
        @(negedge clk);
      end
    end
    for (int k = 1; k < B; k++) begin
      @(negedge clk);
      req_a[i] = 1'b0; data_a[i] = mkword(i, seq, k);
    end
  endtask

  // Monitor: scoreboard comparison at the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (burst_watch && (|out_valid)) begin
        first_out_cyc = cyc;
        burst_watch = 0;
      end
      for (int o = 0; o < N; o++) begin
        if (out_valid[o]) begin
          if (exp_q[o].size() == 0) begin
            check(0, "R1", "unexpected word", out_data[o*W +: W], 0);
          end else begin
            logic [W-1:0] e;
            e = exp_q[o].pop_front();
            check(out_data[o*W +: W] == e, "R1", "word value", out_data[o*W +: W], e);
            check(out_first[o] == (e[3:0] == 4'd0), "R2", "first flag", out_first[o], e[3:0] == 4'd0);
            if (probe_on && out_first[o]) begin
              check(cyc - last_grant[0] == 2, "R7", "cut-through latency", cyc - last_grant[0], 2);
              probe_on = 0;
            end
          end
        end else if (out_first[o]) begin
          check(0, "R2", "first without valid", 1, 0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g1, g2, gmin, gmax, st0;
    for (int i = 0; i < N; i++) begin
      req_a[i] = 1'b0; dest_a[i] = '0; data_a[i] = '0; last_grant[i] = 0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    check(out_valid == '0, "R10", "out_valid after reset", out_valid, 0);
    check(in_stall == '0, "R10", "in_stall after reset", in_stall, 0);
    mon_on = 1;

    // R7: lone packet on the idle buffer
    probe_on = 1;
    send(0, 2, 1);
    repeat (10) @(negedge clk);
    check(probe_on == 0, "R7", "probe packet seen", probe_on, 0);

    // R1: every input to a different output, one after another
    for (int i = 0; i < N; i++) begin
      send(i, (i + 1) % N, 10 + i);
      repeat (8) @(negedge clk);
    end

    // R6: back-to-back packets from one idle input
    send(1, 3, 20);
    g1 = last_grant[1];
    send(1, 0, 21);
    g2 = last_grant[1];
    check(g2 - g1 == B, "R6", "back-to-back grant spacing", g2 - g1, B);
    repeat (20) @(negedge clk);

    // R3 R4 R5 R8: all inputs burst to one output, input 0 sends twice
    grant_log.delete();
    st0 = stall_seen;
    burst_watch = 1;
    fork
      begin send(0, 1, 30); send(0, 1, 31); end
      send(1, 1, 32);
      send(2, 1, 33);
      send(3, 1, 34);
    join
    gmin = grant_log[0]; gmax = grant_log[0];
    for (int j = 0; j < N; j++) begin
      if (grant_log[j] < gmin) gmin = grant_log[j];
      if (grant_log[j] > gmax) gmax = grant_log[j];
    end
    check(gmax - gmin == N - 1, "R5", "burst grant span", gmax - gmin, N - 1);
    for (int j = 1; j < N; j++)
      check(grant_log[j] != grant_log[j-1], "R3", "distinct start cycles", grant_log[j], grant_log[j-1] + 1);
    check(stall_seen > st0, "R8", "stall raised on empty pool", stall_seen - st0, 1);
    check(first_out_cyc - gmin == N + 1, "R4", "reads held behind writes", first_out_cyc - gmin, N + 1);
    repeat (40) @(negedge clk);

    // R9: all slots returned, the pool fills again without a stall
    for (int o = 0; o < N; o++)
      check(exp_q[o].size() == 0, "R9", "packets left undelivered", exp_q[o].size(), 0);
    st0 = stall_seen;
    fork
      send(0, 3, 40);
      send(1, 2, 41);
      send(2, 1, 42);
      send(3, 0, 43);
    join
    check(stall_seen == st0, "R9", "stall after recovery", stall_seen - st0, 0);
    repeat (30) @(negedge clk);
    for (int o = 0; o < N; o++)
      check(exp_q[o].size() == 0, "R9", "final drain", exp_q[o].size(), 0);
    check(in_stall == '0 && out_valid == '0, "R8", "idle at end", {in_stall, out_valid}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule